// File: doc/BRIEF.md
# Bus Packet Sequencer with Turnaround Bubbles

This block takes a packet that an arbiter has already granted and plays it onto a shared bus, one bus cycle per clock. A grant is described by three things: the header command, the identity of the master that owns the packet, and a length code. From these the sequencer produces a run of zero or more idle bubble cycles, then the header cycle, then any data cycles. When no packet is in flight, the bus shows a no-operation cycle.

The sequencer keeps a record of the most recent non-data cycle it drove. Master identities fall into three board groups: memories (identity at or below `LAST_MEM`), caches (identities above `LAST_MEM` and up to `LAST_CACHE`), and everything above `LAST_CACHE`. If the record holds a useful cycle and the new packet's header comes from a master in a different group, the sequencer first drives `BUBBLES` bubble cycles. These give the bus drivers on the two boards time to hand over.

Each output cycle comes with its command, its master and decoded class flags. A `pkt_done` strobe marks the final cycle of a packet. While that strobe is high, the arbiter may present the next grant, so packets can run back to back with no gap.

Top module: `bus_pkt_seq`

## Requirements
- R1: After reset the bus shows command 0 (no-operation) with master 0. All class flags, `pkt_done` and `len_err` are low, and `grant_ready` is high.
- R2: A grant is accepted on a clock edge where `grant_valid` and `grant_ready` are both high. Its first cycle appears on the bus in the following clock cycle. Length code 0 gives a header-only packet, and `pkt_done` is high in that header cycle.
- R3: Length code 1 gives a header followed by one data cycle. Length code 2 gives a header followed by four data cycles. Data cycles carry command 2 and the packet's master, and `pkt_done` is high only in the final cycle.
- R4: Length code 3 is illegal. The packet is sent as header-only, and `len_err` goes high and stays high until reset.
- R5: Command codes are 0 no-operation, 1 bubble, 2 data, 3/4/5 read-block/write-block/write-single request, and 6/7/8 the matching replies. `bus_header` is high for any command other than 0, 1 and 2. `bus_data` is high for command 2, `bus_request` for 3 to 5, and `bus_reply` for 6 to 8.
- R6: Bubbles are inserted when three conditions hold: the last non-data cycle was useful (not 0 or 1), the granted command is a header, and the two masters are in different board groups. In that case exactly `BUBBLES` cycles of command 1, carrying the new packet's master, precede the header.
- R7: No bubbles are inserted when both masters are memories, both are caches, or both are above `LAST_CACHE`.
- R8: The last-non-data record is updated by every cycle that is not a data cycle, including idle no-operation cycles. A packet that follows at least one idle cycle therefore never gets bubbles.
- R9: `grant_ready` is high only while idle or in a packet's final cycle. A grant presented while it is low is ignored and leaves the cycle sequence unchanged.
- R10: The first packet after reset never gets bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant_valid | input | 1 | A granted packet is presented |
| grant_cmd | input | 4 | Header command of the granted packet |
| grant_master | input | ID_W | Master identity of the granted packet |
| grant_len | input | 2 | Length code: 0 one cycle, 1 two, 2 five, 3 illegal |
| grant_ready | output | 1 | Sequencer can take a grant this cycle |
| bus_cmd | output | 4 | Command of the current bus cycle |
| bus_master | output | ID_W | Master identity of the current bus cycle |
| bus_header | output | 1 | Current cycle is a header |
| bus_data | output | 1 | Current cycle is a data cycle |
| bus_request | output | 1 | Current cycle is a request header |
| bus_reply | output | 1 | Current cycle is a reply header |
| pkt_done | output | 1 | Current cycle is the last of its packet |
| len_err | output | 1 | Sticky: an illegal length code was granted |

## Verification
The assertions assume that whenever `grant_valid` is high, `grant_cmd` holds a header code (3 to 8), since a grant always describes a real packet. The property that ties an accepted grant to a bubble or a header on the next cycle depends on this. The stimulus only ever presents request and reply codes. It raises `grant_valid` for exactly one cycle, except for a deliberate pulse while `grant_ready` is low, which tests that such a grant is ignored. Inputs change on the falling edge, so the block never sees an input move at its sampling edge.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int CMD_W = 4;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOOP   = 4'd0,
        CMD_BUBBLE = 4'd1,
        CMD_DATA   = 4'd2,
        CMD_RB_RQ  = 4'd3,
        CMD_WB_RQ  = 4'd4,
        CMD_WS_RQ  = 4'd5,
        CMD_RB_RP  = 4'd6,
        CMD_WB_RP  = 4'd7,
        CMD_WS_RP  = 4'd8
    } cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_BUB,
        PH_HDR,
        PH_DAT
    } phase_e;

    localparam logic [1:0] LEN_ONE  = 2'd0;
    localparam logic [1:0] LEN_TWO  = 2'd1;
    localparam logic [1:0] LEN_FIVE = 2'd2;
endpackage

// File: rtl/seq_cmd_class.sv
module seq_cmd_class
    import seq_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    output logic             useful,
    output logic             is_data,
    output logic             is_header,
    output logic             is_request,
    output logic             is_reply
);
    always_comb begin
        useful     = (cmd != CMD_NOOP) && (cmd != CMD_BUBBLE);
        is_data    = (cmd == CMD_DATA);
        is_header  = useful && !is_data;
        is_request = (cmd == CMD_RB_RQ) || (cmd == CMD_WB_RQ) || (cmd == CMD_WS_RQ);
        is_reply   = (cmd == CMD_RB_RP) || (cmd == CMD_WB_RP) || (cmd == CMD_WS_RP);
    end
endmodule

// File: rtl/seq_board_cmp.sv
module seq_board_cmp #(
    parameter int ID_W       = 4,
    parameter int LAST_MEM   = 1,
    parameter int LAST_CACHE = 5
) (
    input  logic [ID_W-1:0] id_a,
    input  logic [ID_W-1:0] id_b,
    output logic            same
);
    localparam logic [ID_W-1:0] MEM_TOP   = ID_W'(LAST_MEM);
    localparam logic [ID_W-1:0] CACHE_TOP = ID_W'(LAST_CACHE);

    logic a_mem, b_mem, a_cache, b_cache, a_high, b_high;

    always_comb begin
        a_mem   = (id_a <= MEM_TOP);
        b_mem   = (id_b <= MEM_TOP);
        a_high  = (id_a > CACHE_TOP);
        b_high  = (id_b > CACHE_TOP);
        a_cache = !a_mem && !a_high;
        b_cache = !b_mem && !b_high;
        same    = (a_mem && b_mem) || (a_cache && b_cache) || (a_high && b_high);
    end
endmodule

// File: rtl/seq_len_dec.sv
module seq_len_dec
    import seq_pkg::*;
(
    input  logic [1:0] len_code,
    output logic [2:0] n_data,
    output logic       illegal
);
    always_comb begin
        illegal = 1'b0;
        unique case (len_code)
            LEN_ONE:  n_data = 3'd0;
            LEN_TWO:  n_data = 3'd1;
            LEN_FIVE: n_data = 3'd4;
            default: begin
                n_data  = 3'd0;
                illegal = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/bus_pkt_seq.sv
module bus_pkt_seq
    import seq_pkg::*;
#(
    parameter int ID_W       = 4,
    parameter int LAST_MEM   = 1,
    parameter int LAST_CACHE = 5,
    parameter int BUBBLES    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant_valid,
    input  logic [3:0]       grant_cmd,
    input  logic [ID_W-1:0]  grant_master,
    input  logic [1:0]       grant_len,
    output logic             grant_ready,
    output logic [3:0]       bus_cmd,
    output logic [ID_W-1:0]  bus_master,
    output logic             bus_header,
    output logic             bus_data,
    output logic             bus_request,
    output logic             bus_reply,
    output logic             pkt_done,
    output logic             len_err
);
    localparam int MAXC  = (BUBBLES > 4) ? BUBBLES : 4;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam int N_DEC = 3;

    typedef struct packed {
        phase_e                phase;
        logic [CNT_W-1:0]      cnt;
        logic [CMD_W-1:0]      hold_cmd;
        logic [ID_W-1:0]       hold_master;
        logic [2:0]            hold_ndata;
        logic [CMD_W-1:0]      cmd;
        logic [ID_W-1:0]       master;
        logic                  done;
        logic                  err;
        logic [CMD_W-1:0]      lnd_cmd;
        logic [ID_W-1:0]       lnd_master;
    } state_t;

    state_t s_q, s_d;

    logic [CMD_W-1:0] dec_in     [N_DEC];
    logic             dec_useful [N_DEC];
    logic             dec_data   [N_DEC];
    logic             dec_hdr    [N_DEC];
    logic             dec_req    [N_DEC];
    logic             dec_rep    [N_DEC];

    assign dec_in[0] = s_q.cmd;
    assign dec_in[1] = s_q.lnd_cmd;
    assign dec_in[2] = grant_cmd;

    for (genvar i = 0; i < N_DEC; i++) begin : g_dec
        seq_cmd_class u_cls (
            .cmd        (dec_in[i]),
            .useful     (dec_useful[i]),
            .is_data    (dec_data[i]),
            .is_header  (dec_hdr[i]),
            .is_request (dec_req[i]),
            .is_reply   (dec_rep[i])
        );
    end

    logic same_board;
    seq_board_cmp #(
        .ID_W       (ID_W),
        .LAST_MEM   (LAST_MEM),
        .LAST_CACHE (LAST_CACHE)
    ) u_board (
        .id_a (s_q.lnd_master),
        .id_b (grant_master),
        .same (same_board)
    );

    logic [2:0] len_nd;
    logic       len_bad;
    seq_len_dec u_len (
        .len_code (grant_len),
        .n_data   (len_nd),
        .illegal  (len_bad)
    );

    logic need_bub;
    if (BUBBLES == 0) begin : g_no_bub
        assign need_bub = 1'b0;
    end else begin : g_bub
        assign need_bub = dec_useful[1] && dec_hdr[2] && !same_board;
    end

    logic accept;
    assign grant_ready = (s_q.phase == PH_IDLE) || s_q.done;
    assign accept      = grant_valid && grant_ready;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (accept) begin
            s_d.hold_cmd    = grant_cmd;
            s_d.hold_master = grant_master;
            s_d.hold_ndata  = len_nd;
            s_d.master      = grant_master;
            if (len_bad) begin
                s_d.err = 1'b1;
            end
            if (need_bub) begin
                s_d.phase = PH_BUB;
                s_d.cnt   = CNT_W'(BUBBLES - 1);
                s_d.cmd   = CMD_BUBBLE;
            end else begin
                s_d.phase = PH_HDR;
                s_d.cnt   = CNT_W'(len_nd);
                s_d.cmd   = grant_cmd;
            end
        end else begin
            unique case (s_q.phase)
                PH_BUB: begin
                    if (s_q.cnt != '0) begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end else begin
                        s_d.phase  = PH_HDR;
                        s_d.cmd    = s_q.hold_cmd;
                        s_d.master = s_q.hold_master;
                        s_d.cnt    = CNT_W'(s_q.hold_ndata);
                    end
                end
                PH_HDR, PH_DAT: begin
                    if (s_q.cnt != '0) begin
                        s_d.phase  = PH_DAT;
                        s_d.cmd    = CMD_DATA;
                        s_d.master = s_q.hold_master;
                        s_d.cnt    = s_q.cnt - 1'b1;
                    end else begin
                        s_d.phase  = PH_IDLE;
                        s_d.cmd    = CMD_NOOP;
                        s_d.master = '0;
                        s_d.cnt    = '0;
                    end
                end
                default: begin
                    s_d.phase  = PH_IDLE;
                    s_d.cmd    = CMD_NOOP;
                    s_d.master = '0;
                    s_d.cnt    = '0;
                end
            endcase
        end
        s_d.done = ((s_d.phase == PH_HDR) || (s_d.phase == PH_DAT)) && (s_d.cnt == '0);
        if (s_d.cmd != CMD_DATA) begin
            s_d.lnd_cmd    = s_d.cmd;
            s_d.lnd_master = s_d.master;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.phase       <= PH_IDLE;
            s_q.cnt         <= '0;
            s_q.hold_cmd    <= CMD_NOOP;
            s_q.hold_master <= '0;
            s_q.hold_ndata  <= '0;
            s_q.cmd         <= CMD_NOOP;
            s_q.master      <= '0;
            s_q.done        <= 1'b0;
            s_q.err         <= 1'b0;
            s_q.lnd_cmd     <= CMD_NOOP;
            s_q.lnd_master  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_cmd     = s_q.cmd;
    assign bus_master  = s_q.master;
    assign bus_header  = dec_hdr[0];
    assign bus_data    = dec_data[0];
    assign bus_request = dec_req[0];
    assign bus_reply   = dec_rep[0];
    assign pkt_done    = s_q.done;
    assign len_err     = s_q.err;
endmodule

// File: rtl/bus_pkt_seq_chk.sv
module bus_pkt_seq_chk #(
    parameter int ID_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            grant_valid,
    input logic [3:0]      grant_cmd,
    input logic            grant_ready,
    input logic [3:0]      bus_cmd,
    input logic            bus_header,
    input logic            bus_data,
    input logic            bus_request,
    input logic            bus_reply,
    input logic            pkt_done,
    input logic            len_err
);
    AST_DATA_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data |-> $past(bus_header || bus_data)); // R3

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |=> len_err); // R4

    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_header, bus_data}) && $onehot0({bus_request, bus_reply})); // R5

    AST_CLASS_IS_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_request || bus_reply) |-> bus_header); // R5

    AST_BUBBLE_THEN_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == 4'd1) |=> ((bus_cmd == 4'd1) || bus_header)); // R6

    AST_GRANT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_ready) |=> ((bus_cmd == 4'd1) || (bus_cmd == $past(grant_cmd)))); // R2

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && !grant_valid) |=> (bus_cmd == 4'd0)); // R9

    AST_BUSY_NO_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_ready |=> (bus_cmd != 4'd0)); // R9
endmodule

bind bus_pkt_seq bus_pkt_seq_chk #(.ID_W(ID_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_valid (grant_valid),
    .grant_cmd   (grant_cmd),
    .grant_ready (grant_ready),
    .bus_cmd     (bus_cmd),
    .bus_header  (bus_header),
    .bus_data    (bus_data),
    .bus_request (bus_request),
    .bus_reply   (bus_reply),
    .pkt_done    (pkt_done),
    .len_err     (len_err)
);

// File: tb/tb_bus_pkt_seq.sv
module tb_bus_pkt_seq;
    localparam int ID_W = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            grant_valid = 1'b0;
    logic [3:0]      grant_cmd = 4'd0;
    logic [ID_W-1:0] grant_master = '0;
    logic [1:0]      grant_len = 2'd0;
    logic            grant_ready;
    logic [3:0]      bus_cmd;
    logic [ID_W-1:0] bus_master;
    logic            bus_header, bus_data, bus_request, bus_reply, pkt_done, len_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    bus_pkt_seq #(.ID_W(ID_W), .LAST_MEM(1), .LAST_CACHE(5), .BUBBLES(2)) dut (
        .clk(clk), .rst_n(rst_n), .grant_valid(grant_valid), .grant_cmd(grant_cmd),
        .grant_master(grant_master), .grant_len(grant_len), .grant_ready(grant_ready),
        .bus_cmd(bus_cmd), .bus_master(bus_master), .bus_header(bus_header),
        .bus_data(bus_data), .bus_request(bus_request), .bus_reply(bus_reply),
        .pkt_done(pkt_done), .len_err(len_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input string tag, input int cmd, input int m,
                       input int hdr, input int dat, input int done);
        chk({tag, " cmd"}, int'(bus_cmd), cmd);
        chk({tag, " master"}, int'(bus_master), m);
        chk({tag, " header"}, int'(bus_header), hdr);
        chk({tag, " data"}, int'(bus_data), dat);
        chk({tag, " done"}, int'(pkt_done), done);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic issue(input int cmd, input int m, input int len);
        while (!grant_ready) @(negedge clk);
        grant_valid  = 1'b1;
        grant_cmd    = 4'(cmd);
        grant_master = ID_W'(m);
        grant_len    = 2'(len);
        @(posedge clk);
        @(negedge clk);
        grant_valid = 1'b0;
    endtask

    task automatic t_reset();
        cyc("R1 reset", 0, 0, 0, 0, 0);
        chk("R1 ready", int'(grant_ready), 1);
        chk("R1 err", int'(len_err), 0);
        chk("R1 req/rep", int'(bus_request | bus_reply), 0);
    endtask

    task automatic t_first();
        issue(3, 2, 0);
        cyc("R10 R2 first header no bubble", 3, 2, 1, 0, 1);
        chk("R5 request flag", int'(bus_request), 1);
        tick();
        cyc("R2 idle after", 0, 0, 0, 0, 0);
    endtask

    task automatic t_chain();
        issue(6, 0, 2);
        cyc("R8 header after idle no bubble", 6, 0, 1, 0, 0);
        chk("R5 reply flag", int'(bus_reply), 1);
        chk("R9 not ready in header", int'(grant_ready), 0);
        for (int k = 0; k < 4; k++) begin
            tick();
            cyc("R3 five data", 2, 0, 0, 1, (k == 3) ? 1 : 0);
        end
        chk("R9 ready in last", int'(grant_ready), 1);
        issue(5, 3, 1);
        cyc("R6 bubble 1 mem->cache", 1, 3, 0, 0, 0);
        chk("R5 bubble no class", int'(bus_request | bus_reply), 0);
        tick();
        cyc("R6 bubble 2", 1, 3, 0, 0, 0);
        tick();
        cyc("R6 header after bubbles", 5, 3, 1, 0, 0);
        tick();
        cyc("R3 two data", 2, 3, 0, 1, 1);
        issue(4, 4, 0);
        cyc("R7 cache-cache no bubble", 4, 4, 1, 0, 1);
        issue(7, 6, 0);
        cyc("R6 bubble cache->high", 1, 6, 0, 0, 0);
        tick();
        cyc("R6 bubble 2 high", 1, 6, 0, 0, 0);
        tick();
        cyc("R6 header high", 7, 6, 1, 0, 1);
        issue(8, 7, 0);
        cyc("R7 high-high no bubble", 8, 7, 1, 0, 1);
        chk("R5 reply ws", int'(bus_reply), 1);
        tick();
        cyc("R9 idle after chain", 0, 0, 0, 0, 0);
    endtask

    task automatic t_mem();
        issue(3, 1, 0);
        cyc("R2 mem header", 3, 1, 1, 0, 1);
        issue(7, 0, 0);
        cyc("R7 mem-mem no bubble", 7, 0, 1, 0, 1);
        tick();
        cyc("R2 idle", 0, 0, 0, 0, 0);
    endtask

    task automatic t_bad_len();
        chk("R4 err before", int'(len_err), 0);
        issue(5, 2, 3);
        cyc("R4 illegal header only", 5, 2, 1, 0, 1);
        chk("R4 err set", int'(len_err), 1);
        tick();
        cyc("R4 idle", 0, 0, 0, 0, 0);
        issue(3, 3, 0);
        chk("R4 err sticky", int'(len_err), 1);
        tick();
    endtask

    task automatic t_ignore();
        issue(4, 2, 2);
        cyc("R9 busy header", 4, 2, 1, 0, 0);
        grant_valid  = 1'b1;
        grant_cmd    = 4'd8;
        grant_master = 4'd9;
        grant_len    = 2'd0;
        @(posedge clk);
        @(negedge clk);
        grant_valid = 1'b0;
        cyc("R9 ignored grant d1", 2, 2, 0, 1, 0);
        for (int k = 1; k < 4; k++) begin
            tick();
            cyc("R9 ignored grant data", 2, 2, 0, 1, (k == 3) ? 1 : 0);
        end
        tick();
        cyc("R9 idle after ignored", 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        tick();
        t_first();
        t_chain();
        t_mem();
        t_bad_len();
        t_ignore();
        tick();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule